// File: doc/BRIEF.md
# DMA Event Interrupt Aggregator

This block gathers completion and error pulses from a group of DMA engines and turns them into three interrupt request lines for the CPU. There are ten sources. Source 0 marks a finished USB transfer and source 1 a USB address fault. Sources 2 to 9 come from four audio streams, two per source pair, in this order: unit 0 playback, unit 0 capture, unit 1 playback and unit 1 capture. Within each pair the lower, even source reports a full buffer and the upper, odd source reports a half buffer.

Every source has a sticky pending flag and a mask bit. Both sit in one 32-bit register that software reaches over a plain write-strobe/read-data bus. A pulse on a source always sets its pending flag. Software acknowledges a flag by writing 0 to it. Writing 1 to a pending flag does nothing, so a read-modify-write that acknowledges some flags cannot lose others. Each output line is the OR of the pending and unmasked sources assigned to it. The lines are registered.

Top module: `dma_evt_irq_agg`

## Requirements
- R1: After reset every mask bit and pending flag is 0, the register reads 0 and all three interrupt lines are low.
- R2: A one-cycle pulse on source n sets its pending flag whether the source is masked or not. Source n < 2 uses register bit n. Source n >= 2 uses bit n+14.
- R3: A write with 0 in a pending-flag position clears that flag. A write with 1 there leaves the flag as it was, so software cannot set a flag.
- R4: When a pulse on a source and a write of 0 to its pending flag fall in the same cycle, the flag stays set.
- R5: Each write loads all mask bits from the write data. Source n < 2 uses bit n+8 and source n >= 2 uses bit n+22 (1 = enabled). Without a write the mask bits hold.
- R6: Line 0 is high exactly when source 1 is pending and enabled.
- R7: Line 1 is high exactly when at least one of sources 0, 2, 4, 6 or 8 is pending and enabled.
- R8: Line 2 is high exactly when at least one of sources 3, 5, 7 or 9 is pending and enabled.
- R9: The interrupt lines are registered. They change on the same clock edge as the register contents they depend on, so they always match the value the register currently reads.
- R10: Register bits 15..10 and 7..2 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | One pulse per source, bit n = source n |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| irq_o | output | 3 | Interrupt request lines 0..2 |

## Verification
A source pulse and a software write that touches the same pending flag can land in the same cycle. The write may be an acknowledge (0) or a harmless 1. Random stimulus drives sparse pulses together with frequent random writes, so these collisions happen often, and directed cases pin down the acknowledge-versus-event collision on a single flag. After every edge the read data and all three lines are compared with a bench model that puts the event first: it ORs new pulses in after applying the write.

// File: rtl/dma_evt_irq_agg.sv
module dma_evt_irq_agg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  evt_i,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [2:0]  irq_o
);

  localparam logic [9:0] LINE0_SET = 10'b00_0000_0010;
  localparam logic [9:0] LINE1_SET = 10'b01_0101_0101;
  localparam logic [9:0] LINE2_SET = 10'b10_1010_1000;

  logic [9:0] pend_q, mask_q, pend_d, mask_d, act_d;
  logic [9:0] wr_pend, wr_mask;
  logic [2:0] irq_q;

  assign wr_pend = {reg_wdata[23:16], reg_wdata[1:0]};
  assign wr_mask = {reg_wdata[31:24], reg_wdata[9:8]};

  assign pend_d = evt_i | (reg_wr ? (pend_q & wr_pend) : pend_q);
  assign mask_d = reg_wr ? wr_mask : mask_q;
  assign act_d  = pend_d & mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      irq_q  <= {|(act_d & LINE2_SET), |(act_d & LINE1_SET), |(act_d & LINE0_SET)};
    end
  end

  assign reg_rdata = {mask_q[9:2], pend_q[9:2], 6'b0, mask_q[1:0], 6'b0, pend_q[1:0]};
  assign irq_o     = irq_q;

  // R2 / R4: a pulse always leaves its flag set on the next cycle
  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R3: no flag rises without a pulse
  p_no_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == 10'd0));

  // R5: masks hold without a write
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(mask_q));

  // R6 / R7 / R8 / R9: lines track the register each cycle
  p_line0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] == (reg_rdata[1] & reg_rdata[9]));
  p_line1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[1] == |({reg_rdata[0], reg_rdata[16], reg_rdata[18], reg_rdata[20], reg_rdata[22]} &
                  {reg_rdata[8], reg_rdata[24], reg_rdata[26], reg_rdata[28], reg_rdata[30]}));
  p_line2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[2] == |({reg_rdata[17], reg_rdata[19], reg_rdata[21], reg_rdata[23]} &
                  {reg_rdata[25], reg_rdata[27], reg_rdata[29], reg_rdata[31]}));

  // R10: unused bits stay zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:10] == 6'd0) && (reg_rdata[7:2] == 6'd0));

endmodule

// File: tb/test_dma_evt_irq_agg.sv
module test_dma_evt_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt_i = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [9:0] m_pend = '0;
  logic [9:0] m_mask = '0;

  always #2 clk = ~clk;

  dma_evt_irq_agg i_dma_evt_irq_agg (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] pack(logic [9:0] p, logic [9:0] m);
    logic [31:0] r;
    r = '0;
    for (int n = 0; n < 10; n++) begin
      if (n < 2) begin
        r[n] = p[n];
        r[n+8] = m[n];
      end else begin
        r[n+14] = p[n];
        r[n+22] = m[n];
      end
    end
    return r;
  endfunction

  function automatic logic [2:0] lines(logic [9:0] p, logic [9:0] m);
    logic [9:0] a;
    logic [2:0] l;
    a = p & m;
    l[0] = a[1];
    l[1] = a[0] | a[2] | a[4] | a[6] | a[8];
    l[2] = a[3] | a[5] | a[7] | a[9];
    return l;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [31:0] e;
    logic [2:0] l;
    e = pack(m_pend, m_mask);
    l = lines(m_pend, m_mask);
    check("R2 R3 pending", reg_rdata & 32'h00ff_0003, e & 32'h00ff_0003);
    check("R5 mask", reg_rdata & 32'hff00_0300, e & 32'hff00_0300);
    check("R10 unused", reg_rdata & 32'h0000_fcfc, 32'h0);
    check("R6 line0", {31'b0, irq_o[0]}, {31'b0, l[0]});
    check("R7 line1", {31'b0, irq_o[1]}, {31'b0, l[1]});
    check("R8 line2 R9", {31'b0, irq_o[2]}, {31'b0, l[2]});
  endtask

  task automatic step(logic [9:0] ev, logic wr, logic [31:0] wd);
    evt_i = ev;
    reg_wr = wr;
    reg_wdata = wd;
    @(posedge clk);
    m_pend = ev | (wr ? (m_pend & {wd[23:16], wd[1:0]}) : m_pend);
    if (wr) m_mask = {wd[31:24], wd[9:8]};
    #1;
    check_all();
    @(negedge clk);
    evt_i = '0;
    reg_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset rdata", reg_rdata, 32'h0);
    check("R1 reset irq", {29'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: pulses on masked sources still set flags
    step(10'h3ff, 1'b0, '0);
    // R3: writing all ones keeps flags, also enables everything
    step(10'h000, 1'b1, 32'hffff_ffff);
    // R3: acknowledge only source 1 and source 5
    step(10'h000, 1'b1, 32'hffff_ffff & ~32'h0000_0002 & ~(32'h1 << 19));
    // R4: pulse on source 3 while acking it
    step(10'h008, 1'b1, 32'hff00_0300);
    check("R4 collision", {31'b0, reg_rdata[17]}, 32'h1);
    // R9: line 2 high in same cycle as the flag
    check("R9 line2 same cycle", {31'b0, irq_o[2]}, 32'h1);
    // R10: writes to unused bits ignored
    step(10'h000, 1'b1, 32'h0000_fcfc);
    // R6: only source 1 enabled and pending
    step(10'h002, 1'b1, 32'h0000_0200);
    check("R6 line0 alone", {29'b0, irq_o}, 32'h1);
    // R7: source 8 alone
    step(10'h100, 1'b1, 32'h4000_0000);
    check("R7 line1 alone", {29'b0, irq_o}, 32'h2);
    // R5: mask off clears line without touching flag
    step(10'h000, 1'b1, 32'h00ff_0003);
    check("R5 masked off", {29'b0, irq_o}, 32'h0);

    for (int k = 0; k < 3000; k++) begin
      logic [9:0] ev;
      logic wr;
      ev = 10'($urandom) & 10'($urandom) & 10'($urandom);
      wr = ($urandom % 3) == 0;
      step(ev, wr, $urandom);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule